// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request into the address and window-mapping bits that a host bridge needs to issue a PCI configuration cycle. A request has three fields: a bus number, a combined device/function number, and a register offset. The block returns a 24-bit address inside the configuration window. It also returns the map word for that window: a configuration cycle-type code, a flag that passes the low two address bits through, and, for some devices, a device-select bit. Running the PCI cycle itself is left to logic downstream.

A request on bus 0 targets the local segment and produces a type 0 cycle, in which the device is chosen by a single set bit. A 24-bit window cannot hold every select bit. Slots 0 to 12 set an address bit. Slots 13 to 20 set a bit in the upper part of the map word. A request on any other bus produces a type 1 cycle, with bus, device and function packed into the address. Requests with an out-of-range field are rejected with an error pulse. Results are registered, and a single-cycle done pulse follows each legal request.

Top module: `cfg_addr_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `cfg_addr`, `cfg_map`, `cfg_low_en`, `cfg_done` and `req_illegal` are all zero.
- R2: A legal request presented with `req_valid` high raises `cfg_done` for exactly one cycle, on the cycle after the request. `cfg_done` is never high unless a request was presented on the previous cycle.
- R3: Bus number 0 selects a type 0 cycle. `cfg_addr[10:8]` is the function (`req_devfn[2:0]`), `cfg_low_en` is 0, and `cfg_map` bits 3:1 hold the configuration type code 3'b101 with bit 0 clear.
- R4: For a type 0 cycle with slot `req_devfn[7:3]` of 12 or lower, `cfg_addr` bit (slot + 11) is set and `cfg_map[15:4]` is zero.
- R5: For a type 0 cycle with slot 13 to 20, `cfg_map` bit (slot - 5) is set, and `cfg_addr[23:11]` is zero. Exactly one device-select bit is set across `cfg_addr[23:11]` and `cfg_map[15:4]`.
- R6: Any nonzero bus selects a type 1 cycle. `cfg_addr` is (bus << 16) | (devfn << 8) plus the offset. `cfg_low_en` is 1, and `cfg_map` equals 16'h000B (type code 3'b101 in bits 3:1, pass-through bit 0 set).
- R7: The register offset (0 to 255) is added into `cfg_addr[7:0]` for both cycle types.
- R8: A bus, devfn or offset above 255 is illegal. The block pulses `req_illegal` for one cycle after the request, does not assert `cfg_done`, and drives `cfg_addr`, `cfg_map` and `cfg_low_en` to zero.
- R9: On bus 0, a slot above 20 is illegal and is handled as in R8. The same devfn on a nonzero bus is legal.
- R10: Between requests the address and map outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_bus | input | 9 | Bus number; values above 255 are illegal |
| req_devfn | input | 9 | Device (bits 7:3) and function (bits 2:0); values above 255 are illegal |
| req_offset | input | 9 | Configuration register offset; values above 255 are illegal |
| cfg_addr | output | 24 | Address inside the configuration window |
| cfg_map | output | 16 | Map word: device select in bits 15:8, type code in 3:1, pass-through in 0 |
| cfg_low_en | output | 1 | Low address bits passed through (type 1 only) |
| req_illegal | output | 1 | One-cycle pulse for a rejected request |
| cfg_done | output | 1 | One-cycle pulse for a completed legal request |

## Verification
The assertions assume that the request fields are stable and known in the cycle `req_valid` is high. They also assume that each request lasts a single cycle. The bench drives every field and the strobe on the falling clock edge, raises `req_valid` for exactly one cycle per request, and returns it low before the next request. The bench reads results at the next falling edge, then checks one cycle later that the pulse has ended and the outputs are held.

// File: rtl/cfg_addr_pkg.sv
// Package: shared constants and types for the configuration address generator.
// Assumes: map word layout with the cycle-type code in bits 3:1 and the
// low-address pass-through flag in bit 0.
package cfg_addr_pkg;
    typedef enum logic {
        CYC_TYPE0 = 1'b0,
        CYC_TYPE1 = 1'b1
    } cyc_kind_t;

    // Cycle-type code for a configuration access, placed in map bits 3:1.
    localparam logic [2:0] MAP_TYPE_CFG = 3'b101;
endpackage

// File: rtl/cfg_req_check.sv
// Module: cfg_req_check
// Purpose: classifies a request as type 0 or type 1 and decides whether it is
// legal. Assumes the fields are FIELD_W bits wide when legal; any set bit above
// that is out of range. On bus 0 the slot must fit the map select field.
module cfg_req_check #(
    parameter int BUS_W     = 9,
    parameter int FN_W      = 9,
    parameter int OFS_W     = 9,
    parameter int FIELD_W   = 8,
    parameter int MAP_W     = 16,
    parameter int MAP_SHIFT = 5
) (
    input  logic [BUS_W-1:0]      bus,
    input  logic [FN_W-1:0]       devfn,
    input  logic [OFS_W-1:0]      offset,
    output cfg_addr_pkg::cyc_kind_t kind,
    output logic                  legal
);
    import cfg_addr_pkg::*;

    localparam logic [5:0] SLOT_TOP = 6'(MAP_W + MAP_SHIFT - 1);

    logic       range_bad;
    logic       slot_bad;
    logic [4:0] slot;

    assign slot = devfn[7:3];

    // Classify the cycle type and check every field range.
    always_comb begin
        range_bad = (|bus[BUS_W-1:FIELD_W]) | (|devfn[FN_W-1:FIELD_W]) |
                    (|offset[OFS_W-1:FIELD_W]);
        kind      = (bus[FIELD_W-1:0] == '0) ? CYC_TYPE0 : CYC_TYPE1;
        slot_bad  = (kind == CYC_TYPE0) && ({1'b0, slot} > SLOT_TOP);
        legal     = !range_bad && !slot_bad;
    end
endmodule

// File: rtl/cfg_type0_enc.sv
// Module: cfg_type0_enc
// Purpose: builds the local-segment (type 0) address and map select bits.
// Low slots set a one-hot bit in the address; higher slots set a one-hot bit
// in the map word. Assumes the slot has already been range-checked.
module cfg_type0_enc #(
    parameter int ADDR_W     = 24,
    parameter int MAP_W      = 16,
    parameter int DIRECT_MAX = 12,
    parameter int DEV_LSB    = 11,
    parameter int FUNC_LSB   = 8,
    parameter int MAP_SHIFT  = 5
) (
    input  logic [7:0]        devfn,
    output logic [ADDR_W-1:0] addr,
    output logic [MAP_W-1:0]  map_sel
);
    localparam logic [4:0] DIRECT_MAX_S = 5'(DIRECT_MAX);
    localparam logic [4:0] MAP_SHIFT_S  = 5'(MAP_SHIFT);

    logic [4:0] slot;
    logic [2:0] func;
    logic [5:0] addr_pos;
    logic [4:0] map_pos;

    assign slot = devfn[7:3];
    assign func = devfn[2:0];

    // Place the device select bit either in the address or in the map word.
    always_comb begin
        addr_pos = 6'(slot) + 6'(DEV_LSB);
        map_pos  = slot - MAP_SHIFT_S;
        addr     = ADDR_W'(func) << FUNC_LSB;
        map_sel  = '0;
        if (slot <= DIRECT_MAX_S) begin
            addr = addr | (ADDR_W'(1) << addr_pos);
        end else begin
            map_sel = MAP_W'(1) << map_pos;
        end
    end
endmodule

// File: rtl/cfg_type1_enc.sv
// Module: cfg_type1_enc
// Purpose: builds the remote-bus (type 1) address from bus and devfn.
// Assumes both fields are already known to be in range.
module cfg_type1_enc #(
    parameter int ADDR_W  = 24,
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] bus,
    input  logic [FIELD_W-1:0] devfn,
    output logic [ADDR_W-1:0]  addr
);
    // Pack bus above devfn, leaving the low byte free for the offset.
    always_comb begin
        addr = ADDR_W'({bus, devfn}) << FIELD_W;
    end
endmodule

// File: rtl/cfg_addr_gen.sv
// Module: cfg_addr_gen (top)
// Purpose: registers the configuration address and map word for one request
// per strobe, with a done pulse for legal requests and an error pulse for
// illegal ones. Assumes request fields are stable while req_valid is high.
module cfg_addr_gen #(
    parameter int BUS_W      = 9,
    parameter int FN_W       = 9,
    parameter int OFS_W      = 9,
    parameter int FIELD_W    = 8,
    parameter int ADDR_W     = 24,
    parameter int MAP_W      = 16,
    parameter int DIRECT_MAX = 12,
    parameter int DEV_LSB    = 11,
    parameter int FUNC_LSB   = 8,
    parameter int MAP_SHIFT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [FN_W-1:0]   req_devfn,
    input  logic [OFS_W-1:0]  req_offset,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [MAP_W-1:0]  cfg_map,
    output logic              cfg_low_en,
    output logic              req_illegal,
    output logic              cfg_done
);
    import cfg_addr_pkg::*;

    cyc_kind_t         kind;
    logic              legal;
    logic [ADDR_W-1:0] t0_addr;
    logic [MAP_W-1:0]  t0_map;
    logic [ADDR_W-1:0] t1_addr;
    logic [ADDR_W-1:0] next_addr;
    logic [MAP_W-1:0]  next_map;
    logic              next_low;

    cfg_req_check #(
        .BUS_W(BUS_W), .FN_W(FN_W), .OFS_W(OFS_W), .FIELD_W(FIELD_W),
        .MAP_W(MAP_W), .MAP_SHIFT(MAP_SHIFT)
    ) u_check (
        .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
        .kind(kind), .legal(legal)
    );

    cfg_type0_enc #(
        .ADDR_W(ADDR_W), .MAP_W(MAP_W), .DIRECT_MAX(DIRECT_MAX),
        .DEV_LSB(DEV_LSB), .FUNC_LSB(FUNC_LSB), .MAP_SHIFT(MAP_SHIFT)
    ) u_type0 (
        .devfn(req_devfn[7:0]), .addr(t0_addr), .map_sel(t0_map)
    );

    cfg_type1_enc #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
    ) u_type1 (
        .bus(req_bus[FIELD_W-1:0]), .devfn(req_devfn[FIELD_W-1:0]), .addr(t1_addr)
    );

    // Select the encoder result, add the offset and assemble the map word.
    always_comb begin
        next_low  = (kind == CYC_TYPE1);
        next_addr = ((kind == CYC_TYPE1) ? t1_addr : t0_addr) +
                    ADDR_W'(req_offset[FIELD_W-1:0]);
        next_map  = ((kind == CYC_TYPE1) ? '0 : t0_map) |
                    MAP_W'({MAP_TYPE_CFG, next_low});
    end

    // Register results on a request; pulses last a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr    <= '0;
            cfg_map     <= '0;
            cfg_low_en  <= 1'b0;
            req_illegal <= 1'b0;
            cfg_done    <= 1'b0;
        end else begin
            cfg_done    <= req_valid && legal;
            req_illegal <= req_valid && !legal;
            if (req_valid) begin
                cfg_addr   <= legal ? next_addr : '0;
                cfg_map    <= legal ? next_map  : '0;
                cfg_low_en <= legal && next_low;
            end
        end
    end

    // R2: a legal request is followed by done on the next cycle.
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && legal |=> cfg_done);
    // R2: no request, no done.
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !cfg_done && !req_illegal);
    // R8: done and error never together; an error leaves nothing behind.
    a_r8_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && req_illegal));
    a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        req_illegal |-> (cfg_addr == '0) && (cfg_map == '0) && !cfg_low_en);
    // R3, R6: the configuration type code is present on every completion.
    a_r3_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> cfg_map[3:1] == MAP_TYPE_CFG);
    // R6: the pass-through flag follows the bus number of the request.
    a_r6_low_en_type1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && legal |=> cfg_low_en == $past(req_bus != '0));
    // R5: a type 0 result carries exactly one device select bit.
    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done && !cfg_low_en |->
            ($countones(cfg_addr[ADDR_W-1:DEV_LSB]) +
             $countones(cfg_map[MAP_W-1:4])) == 1);
    // R10: outputs hold when no request arrives.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(cfg_addr) && $stable(cfg_map));
endmodule

// File: tb/cfg_addr_gen_bench.sv
// Bench: directed scenarios, one task each, with expected values built from
// the requirement formulas.
module cfg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [8:0]  req_bus = '0;
    logic [8:0]  req_devfn = '0;
    logic [8:0]  req_offset = '0;
    logic [23:0] cfg_addr;
    logic [15:0] cfg_map;
    logic        cfg_low_en;
    logic        req_illegal;
    logic        cfg_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_addr_gen u_cfg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_offset(req_offset), .cfg_addr(cfg_addr),
        .cfg_map(cfg_map), .cfg_low_en(cfg_low_en), .req_illegal(req_illegal),
        .cfg_done(cfg_done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one request for one cycle; return at the falling edge after it.
    task automatic send(input logic [8:0] b, input logic [8:0] f, input logic [8:0] o);
        @(negedge clk);
        req_bus = b; req_devfn = f; req_offset = o; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_legal(string req, logic [23:0] ea, logic [15:0] em, logic el);
        chk(req, "done", 32'(cfg_done), 32'd1);
        chk(req, "illegal", 32'(req_illegal), 32'd0);
        chk(req, "addr", 32'(cfg_addr), 32'(ea));
        chk(req, "map", 32'(cfg_map), 32'(em));
        chk(req, "low_en", 32'(cfg_low_en), 32'(el));
        @(negedge clk);
        chk("R2", "done pulse ended", 32'(cfg_done), 32'd0);
        chk("R10", "addr held", 32'(cfg_addr), 32'(ea));
        chk("R10", "map held", 32'(cfg_map), 32'(em));
    endtask

    task automatic expect_illegal(string req);
        chk(req, "illegal", 32'(req_illegal), 32'd1);
        chk(req, "no done", 32'(cfg_done), 32'd0);
        chk(req, "addr zero", 32'(cfg_addr), 32'd0);
        chk(req, "map zero", 32'(cfg_map), 32'd0);
        chk(req, "low_en zero", 32'(cfg_low_en), 32'd0);
        @(negedge clk);
        chk(req, "illegal pulse ended", 32'(req_illegal), 32'd0);
    endtask

    // Type 0 model from R3, R4, R5 and R7.
    task automatic t0_case(string req, int slot, int fn, int ofs);
        logic [23:0] ea;
        logic [15:0] em;
        ea = 24'(fn << 8) + 24'(ofs);
        em = 16'h000A;
        if (slot <= 12) ea = ea | (24'd1 << (slot + 11));
        else            em = em | (16'd1 << (slot - 5));
        send(9'd0, 9'(slot * 8 + fn), 9'(ofs));
        expect_legal(req, ea, em, 1'b0);
    endtask

    // Type 1 model from R6 and R7.
    task automatic t1_case(string req, int b, int f, int ofs);
        send(9'(b), 9'(f), 9'(ofs));
        expect_legal(req, 24'((b << 16) | (f << 8)) + 24'(ofs), 16'h000B, 1'b1);
    endtask

    task automatic test_reset;
        chk("R1", "addr", 32'(cfg_addr), 0);
        chk("R1", "map", 32'(cfg_map), 0);
        chk("R1", "low_en", 32'(cfg_low_en), 0);
        chk("R1", "done", 32'(cfg_done), 0);
        chk("R1", "illegal", 32'(req_illegal), 0);
    endtask

    task automatic test_idle;
        repeat (3) begin
            @(negedge clk);
            chk("R2", "idle no done", 32'(cfg_done), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle();
        t0_case("R4", 0, 0, 0);
        t0_case("R4", 12, 5, 8'h3C);
        t0_case("R5", 13, 1, 4);
        t0_case("R5", 20, 7, 8'hFF);
        t0_case("R3", 6, 3, 0);
        t1_case("R6", 3, 8'hFF, 8'h10);
        t1_case("R7", 255, 0, 255);
        send(9'd0, 9'd168, 9'd0);
        expect_illegal("R9");
        t1_case("R9", 1, 168, 2);
        send(9'd256, 9'd0, 9'd0);
        expect_illegal("R8");
        send(9'd2, 9'd256, 9'd0);
        expect_illegal("R8");
        send(9'd0, 9'd8, 9'd256);
        expect_illegal("R8");
        test_idle();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule